// File: doc/BRIEF.md
# Checkpoint-Region Validation Filter

This block sits beside the leading core of a redundant core pair whose trailing core verifies execution in checkpoint intervals. It remembers which cache blocks the leading core has written since the last verification that came back acknowledged. When a remote read of a dirty block arrives, the block answers in the same cycle. The answer is either that the response must be forwarded to the trailing core for corroboration, or that the block is already known good and may be answered directly.

Entries are fully associative. Each entry carries the identifier of the checkpoint region it was written in. A boundary pulse closes the newest region and opens a fresh one. Each acknowledgement retires the oldest closed region.

Running out of entries or of region identifiers is an overflow. After an overflow the filter is emptied and every snoop is forwarded. Store logging restarts at the next boundary. Direct answers come back only when every verification outstanding across the overflow has been acknowledged.

Top module: `ckpt_valid_filter`

## Requirements
- R1: After synchronous active-low reset the filter holds no entries, is in normal mode, has no outstanding verifications, and a snoop to any address returns `snp_fwd_o` = 0.
- R2: A store inserts its block address into the newest region. The block address is the upper ADDR_W-OFF_W bits, so two addresses that differ only in the low OFF_W bits name the same block.
- R3: A store is not inserted again when its block is already in the newest region, even when every entry is full. A store to a block held only by an older region gets an entry of its own in the newest region.
- R4: `snp_fwd_o` is combinational. In normal mode it is 1 when `snp_valid_i` is high and the snooped block is held by any region, and 0 on a miss.
- R5: A store and a snoop in the same cycle are resolved store first: a snoop to the block being stored returns 1.
- R6: A `ckpt_i` pulse closes the newest region and opens an empty one. A store in the same cycle as the pulse belongs to the region being closed. The pulse itself removes nothing.
- R7: An `ack_i` pulse with no pre-overflow verification pending clears every entry of the oldest closed region. A snoop in the same cycle sees the state before the clear. An acknowledgement with nothing outstanding has no effect.
- R8: A store that needs a new entry while all ENTRIES entries are valid is an overflow. Filling the filter exactly to ENTRIES is not an overflow.
- R9: A boundary pulse that arrives while REGIONS-1 closed regions are still unacknowledged is an overflow.
- R10: On overflow all entries are cleared, and every snoop from the next cycle returns 1 until normal mode returns.
- R11: After an overflow, stores are ignored until the next boundary pulse. Stores from that pulse on are logged again.
- R12: Normal mode returns only after acknowledgements for every verification outstanding at the overflow, plus the verification sent at the resuming boundary. These acknowledgements retire no region logged after the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid_i | input | 1 | Leading-core store this cycle |
| st_addr_i | input | ADDR_W | Store byte address |
| ckpt_i | input | 1 | Checkpoint boundary; a verification is sent |
| ack_i | input | 1 | Acknowledgement of the oldest outstanding verification |
| snp_valid_i | input | 1 | Remote dirty-read snoop this cycle |
| snp_addr_i | input | ADDR_W | Snoop byte address |
| snp_fwd_o | output | 1 | Response must be forwarded for corroboration |

## Verification
The bench targets a duplicate store at exactly full capacity: a design that deduplicates wrongly overflows and then forwards a snoop that should miss. It checks that a store-bound block survives a retire of an older region holding the same block, and that a store in a boundary cycle lands in the closing region; a design wrong here keeps the block after the matching acknowledgement. The overflow tests count acknowledgements one by one. A design that resumes early answers directly one acknowledgement too soon. A design that lets drain acknowledgements retire regions loses a block logged after the resume, and a design that logs stores during the flush window answers 1 for a block that should miss.

// File: rtl/vf_pkg.sv
// Shared types for the checkpoint-region validation filter.
package vf_pkg;

    // Operating mode of the filter.
    typedef enum logic [1:0] {
        VF_NORMAL = 2'd0,  // logging stores, snoops answered from the entries
        VF_FLUSH  = 2'd1,  // after overflow: no logging, every snoop forwarded
        VF_DRAIN  = 2'd2   // logging again, waiting for pre-resume acknowledgements
    } vf_mode_e;

endpackage

// File: rtl/vf_entry_array.sv
// Fully associative store of block tags, each tagged with a region id.
// Does: one insert per cycle into the lowest free slot, a clear of every
// entry of one region, a full flush, and two parallel lookups (snoop: any
// region; duplicate: a given region).
// Assumes: flush has priority over insert and clear; the inserted entry
// never carries the region id being cleared in the same cycle.
module vf_entry_array #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 6,
    parameter int ENTRIES = 64,
    parameter int REGIONS = 4,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int RID_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1,
    localparam int USED_W = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ins_i,
    input  logic [TAG_W-1:0]  ins_tag_i,
    input  logic [RID_W-1:0]  ins_rid_i,
    input  logic              clr_i,
    input  logic [RID_W-1:0]  clr_rid_i,
    input  logic [TAG_W-1:0]  snp_tag_i,
    output logic              snp_hit_o,
    output logic              dup_o,
    output logic              full_o,
    output logic [USED_W-1:0] used_o
);

    logic             valid_q [ENTRIES];
    logic [TAG_W-1:0] tag_q   [ENTRIES];
    logic [RID_W-1:0] rid_q   [ENTRIES];
    logic [ENTRIES-1:0] sel;
    logic [ENTRIES-1:0] snp_m;
    logic [ENTRIES-1:0] dup_m;

    // Pick the lowest free slot as insert target.
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Per-entry state: flush, then insert, then region clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                rid_q[g]   <= '0;
            end else if (flush_i) begin
                valid_q[g] <= 1'b0;
            end else if (ins_i && sel[g]) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= ins_tag_i;
                rid_q[g]   <= ins_rid_i;
            end else if (clr_i && (rid_q[g] == clr_rid_i)) begin
                valid_q[g] <= 1'b0;
            end
        end

        assign snp_m[g] = valid_q[g] && (tag_q[g] == snp_tag_i);
        assign dup_m[g] = valid_q[g] && (tag_q[g] == ins_tag_i) && (rid_q[g] == ins_rid_i);
    end

    // Reduce the match vectors and count occupancy.
    always_comb begin
        full_o = 1'b1;
        used_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            full_o = full_o & valid_q[i];
            used_o = used_o + USED_W'(valid_q[i]);
        end
    end

    assign snp_hit_o = |snp_m;
    assign dup_o     = |dup_m;

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (used_o == '0));

endmodule

// File: rtl/vf_region_ctrl.sv
// Region bookkeeping and overflow/resync mode control.
// Does: names the newest region, counts closed regions awaiting
// acknowledgement (pend) and acknowledgements owed for untracked intervals
// (drain), chooses which region an acknowledgement retires, and detects
// region overflow.
// Assumes: REGIONS >= 2; acknowledgements return in order; no more than
// 2**CNT_W-1 untracked verifications are ever outstanding at once.
module vf_region_ctrl
    import vf_pkg::*;
#(
    parameter int REGIONS = 4,
    parameter int CNT_W   = 8,
    localparam int RID_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1,
    localparam int PEND_W = $clog2(REGIONS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ckpt_i,
    input  logic             ack_i,
    input  logic             store_ovf_i,
    output vf_mode_e         mode_o,
    output logic [RID_W-1:0] cur_rid_o,
    output logic             clr_o,
    output logic [RID_W-1:0] clr_rid_o,
    output logic             ckpt_ovf_o,
    output logic             flush_o
);

    vf_mode_e          mode_q, mode_d;
    logic [RID_W-1:0]  cur_q, cur_d, cur_nxt;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [CNT_W-1:0]  drain_q, drain_d;
    logic              ack_drain, ack_rgn;

    // Event decode: which counter an acknowledgement belongs to.
    always_comb begin
        ack_drain  = ack_i && (drain_q != '0);
        ack_rgn    = ack_i && (drain_q == '0) && (pend_q != '0);
        ckpt_ovf_o = ckpt_i && (mode_q != VF_FLUSH) && (pend_q == PEND_W'(REGIONS - 1));
        flush_o    = ckpt_ovf_o || store_ovf_i;
        cur_nxt    = (cur_q == RID_W'(REGIONS - 1)) ? '0 : cur_q + 1'b1;
    end

    // Oldest closed region = newest id minus closed count, modulo REGIONS.
    always_comb begin
        int unsigned old_i;
        old_i     = (int'(cur_q) + REGIONS - int'(pend_q)) % REGIONS;
        clr_rid_o = RID_W'(old_i);
        clr_o     = ack_rgn;
    end

    // Next-state for mode and counters.
    always_comb begin
        mode_d  = mode_q;
        pend_d  = pend_q;
        drain_d = drain_q - CNT_W'(ack_drain);
        cur_d   = ckpt_i ? cur_nxt : cur_q;
        if (flush_o) begin
            mode_d  = VF_FLUSH;
            pend_d  = '0;
            drain_d = drain_q - CNT_W'(ack_drain) + CNT_W'(pend_q)
                      - CNT_W'(ack_rgn) + CNT_W'(ckpt_i);
        end else if (mode_q == VF_FLUSH) begin
            if (ckpt_i) begin
                mode_d  = VF_DRAIN;
                drain_d = drain_q - CNT_W'(ack_drain) + 1'b1;
            end
        end else begin
            pend_d = pend_q - PEND_W'(ack_rgn) + PEND_W'(ckpt_i);
            if (drain_d == '0) begin
                mode_d = VF_NORMAL;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= VF_NORMAL;
            cur_q   <= '0;
            pend_q  <= '0;
            drain_q <= '0;
        end else begin
            mode_q  <= mode_d;
            cur_q   <= cur_d;
            pend_q  <= pend_d;
            drain_q <= drain_d;
        end
    end

    assign mode_o    = mode_q;
    assign cur_rid_o = cur_q;

    // R12
    drain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == VF_NORMAL) |-> (drain_q == '0));

    // R9
    rgn_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_i && (mode_q != VF_FLUSH) && (pend_q == PEND_W'(REGIONS - 1)))
        |=> (mode_q == VF_FLUSH));

    // R7
    ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (drain_q == '0) && (pend_q != '0) && !ckpt_i && !store_ovf_i
         && (mode_q != VF_FLUSH))
        |=> (pend_q == PEND_W'($past(pend_q) - 1'b1)));

endmodule

// File: rtl/ckpt_valid_filter.sv
// Checkpoint-region validation filter, top level.
// Does: logs block addresses of leading-core stores per checkpoint region,
// answers dirty-read snoops combinationally with a must-forward flag, retires
// regions on acknowledgement, and runs the overflow flush/resync sequence.
// Assumes: one store and one snoop per cycle at most; a store and a snoop in
// the same cycle are ordered store first.
module ckpt_valid_filter
    import vf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 6,
    parameter int ENTRIES = 64,
    parameter int REGIONS = 4,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              ckpt_i,
    input  logic              ack_i,
    input  logic              snp_valid_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_fwd_o
);

    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int RID_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1;
    localparam int USED_W = $clog2(ENTRIES + 1);

    vf_mode_e          mode;
    logic [TAG_W-1:0]  st_tag, snp_tag;
    logic [RID_W-1:0]  cur_rid, clr_rid;
    logic [USED_W-1:0] used;
    logic              clr, flush, ckpt_ovf;
    logic              snp_hit, dup, full;
    logic              st_log, need_new, store_ovf, ins;

    // Block tags and store classification.
    always_comb begin
        st_tag    = st_addr_i[ADDR_W-1:OFF_W];
        snp_tag   = snp_addr_i[ADDR_W-1:OFF_W];
        st_log    = st_valid_i && (mode != VF_FLUSH);
        need_new  = st_log && !dup;
        store_ovf = need_new && full;
        ins       = need_new && !full;
    end

    // Snoop answer: forced in non-normal modes, store-first bypass otherwise.
    always_comb begin
        snp_fwd_o = snp_valid_i &&
                    ((mode != VF_NORMAL) || snp_hit || (st_log && (st_tag == snp_tag)));
    end

    vf_region_ctrl #(
        .REGIONS (REGIONS),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ckpt_i      (ckpt_i),
        .ack_i       (ack_i),
        .store_ovf_i (store_ovf),
        .mode_o      (mode),
        .cur_rid_o   (cur_rid),
        .clr_o       (clr),
        .clr_rid_o   (clr_rid),
        .ckpt_ovf_o  (ckpt_ovf),
        .flush_o     (flush)
    );

    vf_entry_array #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .ENTRIES (ENTRIES),
        .REGIONS (REGIONS)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .ins_i     (ins),
        .ins_tag_i (st_tag),
        .ins_rid_i (cur_rid),
        .clr_i     (clr),
        .clr_rid_i (clr_rid),
        .snp_tag_i (snp_tag),
        .snp_hit_o (snp_hit),
        .dup_o     (dup),
        .full_o    (full),
        .used_o    (used)
    );

    // R10
    ovf_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!snp_valid_i || snp_fwd_o));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == VF_FLUSH) |-> (used == '0));

    // R3
    dup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_log && dup && !flush && !clr) |=> (used == $past(used)));

    // R8
    ins_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_new && !full && !flush && !clr) |=> (used == USED_W'($past(used) + 1'b1)));

    // R9
    ckpt_ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_ovf |=> (used == '0));

endmodule

// File: tb/ckpt_valid_filter_tb.sv
`timescale 1ns/1ps
module ckpt_valid_filter_tb;

    localparam int AW = 16;
    localparam int NV = 50;

    typedef struct packed {
        logic          st;
        logic [AW-1:0] sa;
        logic          ck;
        logic          ak;
        logic          sv;
        logic [AW-1:0] na;
        logic          ex;
        logic [7:0]    rq;
    } vec_t;

    // Fields: store, store addr, boundary, ack, snoop, snoop addr, expected fwd, req.
    localparam vec_t VECS [NV] = '{
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b0,8'd1},  // 0  R1 empty after reset
        '{1'b1,16'h1000,1'b0,1'b0,1'b1,16'h100F,1'b1,8'd5},  // 1  R5 store-first bypass
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b1,8'd2},  // 2  R2 logged
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b0,8'd4},  // 3  R4 miss
        '{1'b1,16'h100F,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd3},  // 4  R3 duplicate store
        '{1'b0,16'h0000,1'b1,1'b0,1'b1,16'h1000,1'b1,8'd6},  // 5  R6 boundary keeps
        '{1'b1,16'h2000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd2},  // 6  R2
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h1000,1'b1,8'd7},  // 7  R7 pre-ack view
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b0,8'd7},  // 8  R7 retired
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b1,8'd4},  // 9  R4 hit
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 10 R6
        '{1'b1,16'h2000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd3},  // 11 R3 new-region copy
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0000,1'b0,8'd7},  // 12 R7
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b1,8'd3},  // 13 R3 copy survives
        '{1'b1,16'h3000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd8},  // 14 R8
        '{1'b1,16'h4000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd8},  // 15 R8
        '{1'b1,16'h5000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd8},  // 16 R8 now full
        '{1'b1,16'h4000,1'b0,1'b0,1'b1,16'h3000,1'b1,8'd3},  // 17 R3 dup at full
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b0,8'd3},  // 18 R3 no overflow
        '{1'b1,16'h6000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd8},  // 19 R8 overflow
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b1,8'd10}, // 20 R10 forced
        '{1'b1,16'h1000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd11}, // 21 R11 ignored
        '{1'b0,16'h0000,1'b1,1'b0,1'b1,16'h2000,1'b1,8'd10}, // 22 R10 resume edge
        '{1'b1,16'h3000,1'b0,1'b0,1'b1,16'h2000,1'b1,8'd12}, // 23 R12 draining
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h2000,1'b1,8'd12}, // 24 R12 last ack
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h1000,1'b0,8'd11}, // 25 R11 flush store gone
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h3000,1'b1,8'd11}, // 26 R11 logged again
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 27 R6
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 28 R6
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 29 R6 three closed
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd9},  // 30 R9 region overflow
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h7000,1'b1,8'd9},  // 31 R9 forced
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd11}, // 32 R11 resume
        '{1'b1,16'h2000,1'b0,1'b0,1'b0,16'h0000,1'b0,8'd11}, // 33 R11 logged
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h4000,1'b1,8'd12}, // 34 R12 ack 1 of 5
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h4000,1'b1,8'd12}, // 35 R12 ack 2
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h4000,1'b1,8'd12}, // 36 R12 ack 3
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h4000,1'b1,8'd12}, // 37 R12 ack 4
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h4000,1'b1,8'd12}, // 38 R12 ack 5
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h4000,1'b0,8'd12}, // 39 R12 normal again
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b1,8'd12}, // 40 R12 entry kept
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h2000,1'b1,8'd7},  // 41 R7 spurious ack
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b1,8'd7},  // 42 R7 no effect
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 43 R6
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0000,1'b0,8'd7},  // 44 R7
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h2000,1'b0,8'd7},  // 45 R7 retired
        '{1'b1,16'h5000,1'b1,1'b0,1'b0,16'h0000,1'b0,8'd6},  // 46 R6 store in boundary
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h5000,1'b1,8'd6},  // 47 R6
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0000,1'b0,8'd6},  // 48 R6
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,16'h5000,1'b0,8'd6}   // 49 R6 went with closing region
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid_i, ckpt_i, ack_i, snp_valid_i;
    logic [AW-1:0] st_addr_i, snp_addr_i;
    logic          snp_fwd_o;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    ckpt_valid_filter #(
        .ADDR_W  (AW),
        .OFF_W   (4),
        .ENTRIES (4),
        .REGIONS (4),
        .CNT_W   (4)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid_i  (st_valid_i),
        .st_addr_i   (st_addr_i),
        .ckpt_i      (ckpt_i),
        .ack_i       (ack_i),
        .snp_valid_i (snp_valid_i),
        .snp_addr_i  (snp_addr_i),
        .snp_fwd_o   (snp_fwd_o)
    );

    task automatic check(input int rq, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic [AW-1:0] sa, input logic ck,
                         input logic ak, input logic sv, input logic [AW-1:0] na);
        @(negedge clk);
        st_valid_i  = st;
        st_addr_i   = sa;
        ckpt_i      = ck;
        ack_i       = ak;
        snp_valid_i = sv;
        snp_addr_i  = na;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        st_valid_i = 1'b0; ckpt_i = 1'b0; ack_i = 1'b0; snp_valid_i = 1'b0;
        st_addr_i = '0; snp_addr_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].st, VECS[i].sa, VECS[i].ck, VECS[i].ak, VECS[i].sv, VECS[i].na);
            if (VECS[i].sv)
                check(int'(VECS[i].rq), snp_fwd_o, VECS[i].ex, $sformatf("vector %0d", i));
        end
        idle();

        // R8: exactly ENTRIES distinct blocks is not an overflow; one more is.
        do_reset();
        for (int k = 1; k <= 4; k++) drive(1'b1, AW'(k * 16'h1000), 1'b0, 1'b0, 1'b0, '0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h9000);
        check(8, snp_fwd_o, 1'b0, "exactly full, miss answered directly");
        drive(1'b1, 16'h5000, 1'b0, 1'b0, 1'b0, '0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h9000);
        check(8, snp_fwd_o, 1'b1, "one past full forces forward");

        // R1: reset from the flush state returns to normal with nothing logged.
        do_reset();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h9000);
        check(1, snp_fwd_o, 1'b0, "reset leaves overflow mode");
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h1000);
        check(1, snp_fwd_o, 1'b0, "reset empties entries");
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 16'h1000);
        check(4, snp_fwd_o, 1'b0, "no snoop, no forward");
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule